// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block surrounds an embedded core inside a larger chip and gives every core input and every core output terminal a test cell. All cells are joined into one serial wrapper chain with a serial data input and a serial data output. The chip-level test port drives shift, capture and update strobes together with a two-bit mode code. These select whether the wrapper is transparent (normal), tests the surrounding interconnect (external test) or tests the core logic itself (internal test).

Each cell has a shift/capture flop and a separate update register. New data can be shifted through the chain while the values already applied to the core or to the host stay put. The mode code is sampled only on an update strobe, so a mode change and the new applied values take effect together. In external test the input-side cells observe and the output-side cells drive. In internal test those roles swap.

Top module: `core_test_wrapper`

## Requirements
- R1: After reset the wrapper is in normal mode, and every shift/capture flop and update register holds 0, so `wso` reads 0.
- R2: In normal mode (mode code 00, or the unused code 11), `core_in` equals `host_in` and `host_out` equals `core_out`.
- R3: While `shift_en` is high, the chain advances one bit per clock from `wsi` through input cells 0..NUM_IN-1 and then output cells 0..NUM_OUT-1. `wso` shows the flop of the last output cell, so a bit reaches `wso` after NUM_IN+NUM_OUT shifts.
- R4: In external test (mode code 01), `capture_en` loads each input cell's flop with its `host_in` bit.
- R5: In external test, `host_out` is driven from the output cells' update registers, and changes in `core_out` have no effect on it.
- R6: In internal test (mode code 10), `core_in` is driven from the input cells' update registers, and changes in `host_in` have no effect on it.
- R7: In internal test, `capture_en` loads each output cell's flop with its `core_out` bit.
- R8: On capture, a cell that is not on the observing side for the current mode keeps its flop value. This covers input cells in internal test, output cells in external test, and all cells in normal mode.
- R9: `update_en` copies every flop into its update register. Without it, the applied values on `core_in` and `host_out` stay constant while the chain shifts.
- R10: `mode_sel` is sampled only on a cycle with `update_en` high. Changing it at any other time has no effect.
- R11: When `shift_en` and `capture_en` are high in the same cycle, the shift takes place and the capture is dropped.
- R12: When `update_en` and `shift_en` are high in the same cycle, the update registers receive the chain contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode code from the chip test port: 00 normal, 01 external test, 10 internal test, 11 normal |
| shift_en | input | 1 | Advance the wrapper chain by one bit |
| capture_en | input | 1 | Load observing cells from their terminals |
| update_en | input | 1 | Copy the chain into the update registers and sample `mode_sel` |
| wsi | input | 1 | Serial chain input |
| wso | output | 1 | Serial chain output |
| host_in | input | NUM_IN | Host-side values headed for the core inputs |
| core_in | output | NUM_IN | Values applied to the core inputs |
| core_out | input | NUM_OUT | Values produced by the core outputs |
| host_out | output | NUM_OUT | Values presented to the host logic |

## Verification
Two pairs of strobes can fall in the same cycle.

The first pair is update with shift. The bench loads a chain pattern whose one-bit shifted image differs from it in the input cells. It then raises `update_en` and `shift_en` together in internal test and checks that `core_in` shows the pre-shift pattern.

The second pair is shift with capture. The bench presents host values that differ from the chain contents, raises both strobes in external test, and reads the chain out. The result must be the shifted image carrying the `wsi` bit, with no trace of the captured values.

// File: rtl/core_test_wrapper.sv
module core_test_wrapper #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               shift_en,
  input  logic               capture_en,
  input  logic               update_en,
  input  logic               wsi,
  output logic               wso,
  input  logic [NUM_IN-1:0]  host_in,
  output logic [NUM_IN-1:0]  core_in,
  input  logic [NUM_OUT-1:0] core_out,
  output logic [NUM_OUT-1:0] host_out
);

  localparam int CHAIN_LEN = NUM_IN + NUM_OUT;
  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [1:0] MODE_EXT    = 2'b01;
  localparam logic [1:0] MODE_INT    = 2'b10;

  logic [CHAIN_LEN-1:0] scan_q, hold_q, cap_val, scan_d;
  logic [1:0] mode_q;
  logic ext_mode, int_mode;

  assign ext_mode = (mode_q == MODE_EXT);
  assign int_mode = (mode_q == MODE_INT);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in_cell
    assign cap_val[i] = ext_mode ? host_in[i] : scan_q[i];
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out_cell
    assign cap_val[NUM_IN+j] = int_mode ? core_out[j] : scan_q[NUM_IN+j];
  end

  always_comb begin
    if (shift_en)        scan_d = {scan_q[CHAIN_LEN-2:0], wsi};
    else if (capture_en) scan_d = cap_val;
    else                 scan_d = scan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= '0;
      hold_q <= '0;
      mode_q <= MODE_NORMAL;
    end else begin
      scan_q <= scan_d;
      if (update_en) begin
        hold_q <= scan_q;
        mode_q <= mode_sel;
      end
    end
  end

  assign wso      = scan_q[CHAIN_LEN-1];
  assign core_in  = int_mode ? hold_q[NUM_IN-1:0] : host_in;
  assign host_out = ext_mode ? hold_q[CHAIN_LEN-1:NUM_IN] : core_out;

  // R3
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> scan_q[0] == $past(wsi));

  // R3
  shift_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> wso == $past(scan_q[CHAIN_LEN-2]));

  // R4
  ext_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && !shift_en && ext_mode) |=> scan_q[NUM_IN-1:0] == $past(host_in));

  // R7
  int_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && !shift_en && int_mode) |=> scan_q[CHAIN_LEN-1:NUM_IN] == $past(core_out));

  // R5
  ext_drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !update_en) |=> $stable(host_out));

  // R6
  int_drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && !update_en) |=> $stable(core_in));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(mode_q));

  // R12
  update_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> hold_q == $past(scan_q));

endmodule

// File: tb/tb_core_test_wrapper.sv
module tb_core_test_wrapper;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int NC = NI + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0, wsi = 1'b0;
  logic wso;
  logic [NI-1:0] host_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out;
  logic [NO-1:0] host_out;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [NO-1:0] core_fn(input logic [NI-1:0] x);
    return {x[3] ^ x[0], x[2] & x[1], x[1] | x[3]};
  endfunction

  assign core_out = core_fn(core_in);

  core_test_wrapper #(.NUM_IN(NI), .NUM_OUT(NO)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .wsi(wsi), .wso(wso),
    .host_in(host_in), .core_in(core_in), .core_out(core_out), .host_out(host_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic shift_vec(input logic [NC-1:0] v, output logic [NC-1:0] got);
    shift_en = 1'b1;
    for (int j = 0; j < NC; j++) begin
      wsi = v[NC-1-j];
      got[NC-1-j] = wso;
      @(negedge clk);
    end
    shift_en = 1'b0;
  endtask

  task automatic do_update(input logic [1:0] m);
    mode_sel = m;
    update_en = 1'b1;
    @(negedge clk);
    update_en = 1'b0;
  endtask

  task automatic do_capture();
    capture_en = 1'b1;
    @(negedge clk);
    capture_en = 1'b0;
  endtask

  initial begin
    logic [NC-1:0] got;
    logic [NC-1:0] pat;
    logic [NO-1:0] o;
    host_in = 4'h5;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(wso == 1'b0, "R1", wso, 0);
    check(core_in == 4'h5 && host_out == core_fn(4'h5), "R1", core_in, 5);
    rst_n = 1'b1;
    @(negedge clk);
    shift_vec('0, got);
    check(got == '0, "R1", got, 0);

    // R2 normal sweep
    for (int v = 0; v < 16; v++) begin
      host_in = v[NI-1:0];
      @(negedge clk);
      check(core_in == v[NI-1:0], "R2", core_in, v);
      check(host_out == core_fn(v[NI-1:0]), "R2", host_out, core_fn(v[NI-1:0]));
    end

    // R3 chain order and length
    pat = 7'b1011001;
    shift_vec(pat, got);
    shift_vec('0, got);
    check(got == pat, "R3", got, pat);
    shift_vec(7'b0000001, got);
    shift_en = 1'b1; wsi = 1'b0;
    repeat (NC - 1) @(negedge clk);
    shift_en = 1'b0;
    check(wso == 1'b1, "R3", wso, 1);

    // R8 capture in normal mode holds all cells
    shift_vec(7'b0110101, got);
    host_in = 4'hA;
    do_capture();
    shift_vec('0, got);
    check(got == 7'b0110101, "R8", got, 7'b0110101);

    // R4 R5 R8 external test sweep
    for (int v = 0; v < 16; v++) begin
      o = v[NO-1:0] ^ 3'b101;
      shift_vec({o, 4'b0000}, got);
      do_update(2'b01);
      host_in = v[NI-1:0];
      @(negedge clk);
      check(host_out == o, "R5", host_out, o);
      host_in = ~v[NI-1:0];
      @(negedge clk);
      check(host_out == o, "R5", host_out, o);
      host_in = v[NI-1:0];
      do_capture();
      shift_vec({o, 4'b0000}, got);
      check(got[NI-1:0] == v[NI-1:0], "R4", got[NI-1:0], v);
      check(got[NC-1:NI] == o, "R8", got[NC-1:NI], o);
    end

    // R6 R7 R8 R9 internal test sweep
    for (int v = 0; v < 16; v++) begin
      shift_vec({3'b000, v[NI-1:0]}, got);
      do_update(2'b10);
      host_in = ~v[NI-1:0];
      @(negedge clk);
      check(core_in == v[NI-1:0], "R6", core_in, v);
      check(host_out == core_fn(v[NI-1:0]), "R6", host_out, core_fn(v[NI-1:0]));
      do_capture();
      shift_vec(7'b1111111, got);
      check(core_in == v[NI-1:0], "R9", core_in, v);
      check(got[NC-1:NI] == core_fn(v[NI-1:0]), "R7", got[NC-1:NI], core_fn(v[NI-1:0]));
      check(got[NI-1:0] == v[NI-1:0], "R8", got[NI-1:0], v);
    end

    // R10 mode_sel ignored without update
    do_update(2'b00);
    mode_sel = 2'b10;
    host_in = 4'h9;
    repeat (3) @(negedge clk);
    check(core_in == 4'h9, "R10", core_in, 9);
    shift_vec(7'b0000110, got);
    do_update(2'b11);
    host_in = 4'h3;
    @(negedge clk);
    check(core_in == 4'h3, "R10", core_in, 3);
    check(host_out == core_fn(4'h3), "R2", host_out, core_fn(4'h3));

    // R11 shift wins over capture
    shift_vec(7'b0100110, got);
    do_update(2'b01);
    host_in = 4'hF;
    wsi = 1'b1; shift_en = 1'b1; capture_en = 1'b1;
    @(negedge clk);
    shift_en = 1'b0; capture_en = 1'b0;
    shift_vec('0, got);
    check(got == 7'b1001101, "R11", got, 7'b1001101);

    // R12 update concurrent with shift uses pre-shift contents
    shift_vec(7'b0001010, got);
    mode_sel = 2'b10; update_en = 1'b1; shift_en = 1'b1; wsi = 1'b0;
    @(negedge clk);
    update_en = 1'b0; shift_en = 1'b0;
    host_in = 4'h0;
    @(negedge clk);
    check(core_in == 4'hA, "R12", core_in, 4'hA);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule